// File: doc/BRIEF.md
# Prime-Permutation Block Interleaver Address Generator

This block produces the read order of a block interleaver whose input is viewed as written row by row into a matrix of R rows and C columns, so that input position `row*C + col` sits at (row, col). Three permutation stages define the output order. First, the cells of each row are reordered by a rule built on a prime p and a primitive root v of p. Second, the rows are reordered by a per-block row table. Third, the matrix is read column by column. Positions at or beyond the block length K are padding and are dropped. Exactly K addresses come out, and together they cover every value from 0 to K-1 once.

A one-cycle `start` pulse, given while the block is idle, captures the whole configuration. The block then fills a small internal table with the base sequence and selects one scrambling prime per row. After that it streams addresses under a valid/ready handshake, at up to one address per clock. Choosing R, C, p, v and the row table for a given K is left to the surrounding logic. Each block may use a different configuration.

Top module: `prime_ilv_addr_gen`

## Requirements
- R1: After reset, `addrValid` and `done` are low and stay low until a block is started.
- R2: The base sequence is s(0)=1 and s(j) = (v*s(j-1)) mod p, for j from 1 to p-2.
- R3: Row slot 0 uses scrambling prime q=1. Row slot i>0 uses the i-th smallest prime above 6 that does not divide p-1, taken in increasing order.
- R4: The address emitted for column j and row slot i is `rowOrder[i]*C + U`. Here `rowOrder[i]` is the 5-bit field at bits [5i+4:5i]. U is s((j*q_i) mod (p-1)) when C=p or C=p+1, and that value minus 1 when C=p-1, for j < p-1. U is 0 for j=p-1 and p for j=p.
- R5: Positions are visited column by column: all row slots 0..R-1 of column 0, then all slots of column 1, and so on.
- R6: A position whose address is K or more is skipped without a handshake. Exactly K addresses are emitted per block, and no address is offered after the last one.
- R7: `done` is high together with the K-th address, and never with any other address.
- R8: While `addrValid` is high and `addrReady` is low, `addr`, `addrValid` and `done` hold their values.
- R9: A `start` pulse received while a block is in progress has no effect on the address stream.
- R10: The configuration inputs are sampled only on the accepted `start`. Changing them while a block is in progress has no effect.
- R11: Consecutive blocks may use different K, R, C, p, v and row tables. Each block follows its own configuration.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin a block (accepted only when idle) |
| blkLen | input | 13 | Block length K, 40..5114 |
| numRows | input | 5 | Matrix rows R, 2..20 |
| numCols | input | 9 | Matrix columns C, one of p-1, p, p+1 |
| prime | input | 9 | Prime p, 7..257 |
| primRoot | input | 5 | Primitive root v of p |
| rowOrder | input | 100 | Row table, 5 bits per row slot, slot i at bits [5i+4:5i] |
| addrReady | input | 1 | Consumer accepts the offered address |
| addrValid | output | 1 | An address is offered |
| addr | output | 13 | Interleaved read address |
| done | output | 1 | Offered address is the last of the block |

## Verification
The assertions assume that each configuration is consistent: p is prime, v is a primitive root of p, C is one of p-1, p or p+1, R*C is at least K, and the row table is a permutation of 0..R-1. Under these conditions the three stages form a true permutation, the prime scan never runs off its table, and the emitted count never reaches K before the stream ends. The bench builds every configuration from K with its own rules, which keeps it inside these assumptions. It picks the smallest prime p that gives R*(p+1) >= K and the smallest primitive root by an order test. The row table is a random permutation, apart from directed cases that reverse it. Deliberate disturbances touch only the start pulse and the configuration pins during a block.

// File: rtl/ilv_pkg.sv
package ilv_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_SEQ,
    ST_PRIME,
    ST_RUN,
    ST_DRAIN
  } ilvState_t;

  typedef struct packed {
    logic cfgLoad;
    logic seqWrite;
    logic primeScan;
    logic runInit;
    logic stepCand;
    logic loadOut;
    logic dropOut;
    logic lastFlag;
  } ilvStrobe_t;

  function automatic bit isPrimeNum(int x);
    if (x < 2) return 1'b0;
    for (int d = 2; d * d <= x; d++) begin
      if (x % d == 0) return 1'b0;
    end
    return 1'b1;
  endfunction

  // n-th (0-based) prime strictly greater than 6
  function automatic int rowPrimeAt(int n);
    int found;
    int cand;
    found = -1;
    cand  = 6;
    while (found < n) begin
      cand++;
      if (isPrimeNum(cand)) found++;
    end
    return cand;
  endfunction

endpackage

// File: rtl/ilv_ctrl.sv
module ilv_ctrl
  import ilv_pkg::*;
#(
  parameter int MAX_ROWS    = 20,
  parameter int MAX_PRIME   = 257,
  parameter int MAX_LEN     = 5114,
  parameter int NUM_QPRIMES = 24
) (
  input  logic                      clk,
  input  logic                      rstN,
  input  logic                      start,
  input  logic                      outReady,
  input  logic                      outValid,
  input  logic                      primeHit,
  input  logic                      candPad,
  input  logic [$clog2(MAX_LEN+1)-1:0]   cfgLen,
  input  logic [$clog2(MAX_ROWS+1)-1:0]  cfgRows,
  input  logic [$clog2(MAX_PRIME+2)-1:0] cfgCols,
  input  logic [$clog2(MAX_PRIME+1)-1:0] cfgPrime,
  output ilvStrobe_t                strb,
  output logic                      busy,
  output logic [$clog2(MAX_PRIME-1)-1:0] seqIdx,
  output logic [$clog2(NUM_QPRIMES)-1:0] primeIdx,
  output logic [$clog2(MAX_ROWS)-1:0]    qRow,
  output logic [$clog2(MAX_ROWS)-1:0]    rowIdx,
  output logic [$clog2(MAX_PRIME+2)-1:0] colIdx
);

  localparam int LEN_W   = $clog2(MAX_LEN + 1);
  localparam int ROW_W   = $clog2(MAX_ROWS + 1);
  localparam int COL_W   = $clog2(MAX_PRIME + 2);
  localparam int PRIME_W = $clog2(MAX_PRIME + 1);

  ilvState_t state, nextState;
  logic [LEN_W-1:0] emitCnt;
  logic seqDone, qRowLast, rowLast, lastHit, canStep;

  assign seqDone  = (PRIME_W'(seqIdx) == cfgPrime - PRIME_W'(2));
  assign qRowLast = (ROW_W'(qRow) == cfgRows - ROW_W'(1));
  assign rowLast  = (ROW_W'(rowIdx) == cfgRows - ROW_W'(1));
  assign lastHit  = (emitCnt == cfgLen - LEN_W'(1));
  assign canStep  = candPad || !outValid || outReady;
  assign busy     = (state != ST_IDLE);

  always_comb begin
    strb      = '0;
    nextState = state;
    case (state)
      ST_IDLE: begin
        if (start) begin
          strb.cfgLoad = 1'b1;
          nextState    = ST_SEQ;
        end
      end
      ST_SEQ: begin
        strb.seqWrite = 1'b1;
        if (seqDone) nextState = ST_PRIME;
      end
      ST_PRIME: begin
        strb.primeScan = 1'b1;
        if (primeHit && qRowLast) begin
          strb.runInit = 1'b1;
          nextState    = ST_RUN;
        end
      end
      ST_RUN: begin
        strb.stepCand = canStep;
        strb.loadOut  = canStep && !candPad;
        strb.lastFlag = lastHit;
        if (strb.loadOut && lastHit) nextState = ST_DRAIN;
      end
      ST_DRAIN: begin
        if (outValid && outReady) nextState = ST_IDLE;
      end
      default: nextState = ST_IDLE;
    endcase
    strb.dropOut = outValid && outReady && !strb.loadOut;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state    <= ST_IDLE;
      seqIdx   <= '0;
      primeIdx <= '0;
      qRow     <= '0;
      rowIdx   <= '0;
      colIdx   <= '0;
      emitCnt  <= '0;
    end else begin
      state <= nextState;
      case (state)
        ST_IDLE: seqIdx <= $bits(seqIdx)'(1);
        ST_SEQ: begin
          seqIdx   <= seqIdx + 1'b1;
          primeIdx <= '0;
          qRow     <= $bits(qRow)'(1);
        end
        ST_PRIME: begin
          primeIdx <= primeIdx + 1'b1;
          if (primeHit) qRow <= qRow + 1'b1;
          rowIdx  <= '0;
          colIdx  <= '0;
          emitCnt <= '0;
        end
        ST_RUN: begin
          if (strb.stepCand) begin
            if (rowLast) begin
              rowIdx <= '0;
              colIdx <= colIdx + 1'b1;
            end else begin
              rowIdx <= rowIdx + 1'b1;
            end
          end
          if (strb.loadOut) emitCnt <= emitCnt + 1'b1;
        end
        default: ;
      endcase
    end
  end

  // R2
  seq_idx_range_chk: assert property (@(posedge clk) disable iff (!rstN)
    strb.seqWrite |-> (PRIME_W'(seqIdx) < cfgPrime - PRIME_W'(1)));

  // R3
  prime_table_chk: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_PRIME) |-> (int'(primeIdx) < NUM_QPRIMES));

  // R5
  col_range_chk: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_RUN) |-> (colIdx < cfgCols && ROW_W'(rowIdx) < cfgRows));

  // R6
  emit_bound_chk: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_RUN) |-> (emitCnt < cfgLen));

  // R7
  drain_valid_chk: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_DRAIN) |-> outValid);

  // R9
  busy_start_chk: assert property (@(posedge clk) disable iff (!rstN)
    (busy && start) |=> (state != ST_SEQ || $past(state) == ST_SEQ));

  logic unusedColW;
  assign unusedColW = ^COL_W;

endmodule

// File: rtl/ilv_datapath.sv
module ilv_datapath
  import ilv_pkg::*;
#(
  parameter int MAX_ROWS    = 20,
  parameter int MAX_PRIME   = 257,
  parameter int MAX_LEN     = 5114,
  parameter int ROOT_W      = 5,
  parameter int NUM_QPRIMES = 24
) (
  input  logic                      clk,
  input  logic                      rstN,
  input  ilvStrobe_t                strb,
  input  logic                      busy,
  input  logic                      outReady,
  input  logic [$clog2(MAX_LEN+1)-1:0]   inLen,
  input  logic [$clog2(MAX_ROWS+1)-1:0]  inRows,
  input  logic [$clog2(MAX_PRIME+2)-1:0] inCols,
  input  logic [$clog2(MAX_PRIME+1)-1:0] inPrime,
  input  logic [ROOT_W-1:0]              inRoot,
  input  logic [MAX_ROWS*$clog2(MAX_ROWS)-1:0] inOrder,
  input  logic [$clog2(MAX_PRIME-1)-1:0] seqIdx,
  input  logic [$clog2(NUM_QPRIMES)-1:0] primeIdx,
  input  logic [$clog2(MAX_ROWS)-1:0]    qRow,
  input  logic [$clog2(MAX_ROWS)-1:0]    rowIdx,
  input  logic [$clog2(MAX_PRIME+2)-1:0] colIdx,
  output logic [$clog2(MAX_LEN+1)-1:0]   cfgLen,
  output logic [$clog2(MAX_ROWS+1)-1:0]  cfgRows,
  output logic [$clog2(MAX_PRIME+2)-1:0] cfgCols,
  output logic [$clog2(MAX_PRIME+1)-1:0] cfgPrime,
  output logic                      primeHit,
  output logic                      candPad,
  output logic                      outValid,
  output logic                      outLast,
  output logic [$clog2(MAX_ROWS*(MAX_PRIME+1))-1:0] outAddr
);

  localparam int LEN_W   = $clog2(MAX_LEN + 1);
  localparam int COL_W   = $clog2(MAX_PRIME + 2);
  localparam int PRIME_W = $clog2(MAX_PRIME + 1);
  localparam int RIDX_W  = $clog2(MAX_ROWS);
  localparam int SIDX_W  = $clog2(MAX_PRIME - 1);
  localparam int S_DEPTH = MAX_PRIME - 1;
  localparam int ADDR_W  = $clog2(MAX_ROWS * (MAX_PRIME + 1));
  localparam int PROD_W  = PRIME_W + ROOT_W;

  // configuration captured at start
  logic [ROOT_W-1:0] cfgRoot;
  logic [RIDX_W-1:0] orderR [MAX_ROWS];

  // base sequence store and scan state
  logic [PRIME_W-1:0] seqMem [S_DEPTH];
  logic [PRIME_W-1:0] seqPrev;
  logic [SIDX_W-1:0]  qModR  [MAX_ROWS];
  logic [SIDX_W-1:0]  accR   [MAX_ROWS];

  // fixed table of candidate row primes
  logic [PRIME_W-1:0] primeTab [NUM_QPRIMES];
  for (genvar gp = 0; gp < NUM_QPRIMES; gp++) begin : g_ptab
    localparam int QP = rowPrimeAt(gp);
    assign primeTab[gp] = PRIME_W'(QP);
  end

  logic [PRIME_W-1:0] pm1;
  logic [PROD_W-1:0]  seqProd;
  logic [PRIME_W-1:0] seqNext;
  logic [PRIME_W-1:0] scanPrime;
  logic [SIDX_W-1:0]  scanMod;

  assign pm1       = cfgPrime - PRIME_W'(1);
  assign seqProd   = PROD_W'(cfgRoot) * PROD_W'(seqPrev);
  assign seqNext   = PRIME_W'(seqProd % PROD_W'(cfgPrime));
  assign scanPrime = (int'(primeIdx) < NUM_QPRIMES) ? primeTab[primeIdx] : PRIME_W'(1);
  assign primeHit  = ((pm1 % scanPrime) != '0);
  assign scanMod   = SIDX_W'(scanPrime % pm1);

  // candidate address for (colIdx, rowIdx)
  logic [SIDX_W-1:0]  accCur;
  logic [PRIME_W-1:0] seqVal;
  logic [PRIME_W-1:0] colVal;
  logic [ADDR_W-1:0]  candAddr;
  logic [SIDX_W:0]    accSum;
  logic [SIDX_W-1:0]  accNext;

  assign accCur = accR[rowIdx];
  assign seqVal = seqMem[accCur];

  always_comb begin
    if (PRIME_W'(colIdx) < pm1) begin
      colVal = (cfgCols == COL_W'(pm1)) ? seqVal - PRIME_W'(1) : seqVal;
    end else if (PRIME_W'(colIdx) == pm1) begin
      colVal = '0;
    end else begin
      colVal = cfgPrime;
    end
  end

  assign candAddr = ADDR_W'(orderR[rowIdx]) * ADDR_W'(cfgCols) + ADDR_W'(colVal);
  assign candPad  = (candAddr >= ADDR_W'(cfgLen));

  assign accSum = {1'b0, accCur} + {1'b0, qModR[rowIdx]};
  always_comb begin
    if (PRIME_W'(accSum) >= pm1) accNext = SIDX_W'(PRIME_W'(accSum) - pm1);
    else                         accNext = accSum[SIDX_W-1:0];
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      cfgLen   <= '0;
      cfgRows  <= '0;
      cfgCols  <= '0;
      cfgPrime <= '0;
      cfgRoot  <= '0;
      seqPrev  <= '0;
    end else if (strb.cfgLoad) begin
      cfgLen   <= inLen;
      cfgRows  <= inRows;
      cfgCols  <= inCols;
      cfgPrime <= inPrime;
      cfgRoot  <= inRoot;
      seqPrev  <= PRIME_W'(1);
    end else if (strb.seqWrite) begin
      seqPrev  <= seqNext;
    end
  end

  always_ff @(posedge clk) begin
    if (strb.cfgLoad) begin
      for (int i = 0; i < MAX_ROWS; i++) orderR[i] <= inOrder[i*RIDX_W +: RIDX_W];
    end
  end

  always_ff @(posedge clk) begin
    if (strb.cfgLoad)       seqMem[0]      <= PRIME_W'(1);
    else if (strb.seqWrite) seqMem[seqIdx] <= seqNext;
  end

  always_ff @(posedge clk) begin
    if (strb.cfgLoad)                   qModR[0]    <= SIDX_W'(1);
    else if (strb.primeScan && primeHit) qModR[qRow] <= scanMod;
  end

  always_ff @(posedge clk) begin
    if (strb.runInit) begin
      for (int i = 0; i < MAX_ROWS; i++) accR[i] <= '0;
    end else if (strb.stepCand) begin
      accR[rowIdx] <= accNext;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      outValid <= 1'b0;
      outLast  <= 1'b0;
      outAddr  <= '0;
    end else if (strb.loadOut) begin
      outValid <= 1'b1;
      outLast  <= strb.lastFlag;
      outAddr  <= candAddr;
    end else if (strb.dropOut) begin
      outValid <= 1'b0;
      outLast  <= 1'b0;
    end
  end

  // R8
  hold_addr_chk: assert property (@(posedge clk) disable iff (!rstN)
    (outValid && !outReady) |=> (outValid && $stable(outAddr) && $stable(outLast)));

  // R6
  addr_range_chk: assert property (@(posedge clk) disable iff (!rstN)
    outValid |-> (outAddr < ADDR_W'(cfgLen)));

  // R10
  cfg_stable_chk: assert property (@(posedge clk) disable iff (!rstN)
    busy |=> ($stable(cfgLen) && $stable(cfgPrime) && $stable(cfgCols) && $stable(cfgRows)));

  // R2
  seq_nonzero_chk: assert property (@(posedge clk) disable iff (!rstN)
    strb.seqWrite |-> (seqNext != '0));

  logic unusedLenW;
  assign unusedLenW = ^LEN_W;

endmodule

// File: rtl/prime_ilv_addr_gen.sv
module prime_ilv_addr_gen
  import ilv_pkg::*;
#(
  parameter int MAX_ROWS    = 20,
  parameter int MAX_PRIME   = 257,
  parameter int MAX_LEN     = 5114,
  parameter int ROOT_W      = 5,
  parameter int NUM_QPRIMES = 24,
  localparam int LEN_W   = $clog2(MAX_LEN + 1),
  localparam int ROW_W   = $clog2(MAX_ROWS + 1),
  localparam int COL_W   = $clog2(MAX_PRIME + 2),
  localparam int PRIME_W = $clog2(MAX_PRIME + 1),
  localparam int RIDX_W  = $clog2(MAX_ROWS),
  localparam int ADDR_W  = $clog2(MAX_ROWS * (MAX_PRIME + 1))
) (
  input  logic                       clk,
  input  logic                       rstN,
  input  logic                       start,
  input  logic [LEN_W-1:0]           blkLen,
  input  logic [ROW_W-1:0]           numRows,
  input  logic [COL_W-1:0]           numCols,
  input  logic [PRIME_W-1:0]         prime,
  input  logic [ROOT_W-1:0]          primRoot,
  input  logic [MAX_ROWS*RIDX_W-1:0] rowOrder,
  input  logic                       addrReady,
  output logic                       addrValid,
  output logic [ADDR_W-1:0]          addr,
  output logic                       done
);

  localparam int SIDX_W = $clog2(MAX_PRIME - 1);
  localparam int PIDX_W = $clog2(NUM_QPRIMES);

  ilvStrobe_t          strb;
  logic                busy;
  logic [SIDX_W-1:0]   seqIdx;
  logic [PIDX_W-1:0]   primeIdx;
  logic [RIDX_W-1:0]   qRow, rowIdx;
  logic [COL_W-1:0]    colIdx;
  logic [LEN_W-1:0]    cfgLen;
  logic [ROW_W-1:0]    cfgRows;
  logic [COL_W-1:0]    cfgCols;
  logic [PRIME_W-1:0]  cfgPrime;
  logic                primeHit, candPad, outLast;

  ilv_ctrl #(
    .MAX_ROWS(MAX_ROWS), .MAX_PRIME(MAX_PRIME),
    .MAX_LEN(MAX_LEN), .NUM_QPRIMES(NUM_QPRIMES)
  ) u_ctrl (
    .clk(clk), .rstN(rstN), .start(start), .outReady(addrReady),
    .outValid(addrValid), .primeHit(primeHit), .candPad(candPad),
    .cfgLen(cfgLen), .cfgRows(cfgRows), .cfgCols(cfgCols), .cfgPrime(cfgPrime),
    .strb(strb), .busy(busy), .seqIdx(seqIdx), .primeIdx(primeIdx),
    .qRow(qRow), .rowIdx(rowIdx), .colIdx(colIdx)
  );

  ilv_datapath #(
    .MAX_ROWS(MAX_ROWS), .MAX_PRIME(MAX_PRIME), .MAX_LEN(MAX_LEN),
    .ROOT_W(ROOT_W), .NUM_QPRIMES(NUM_QPRIMES)
  ) u_dp (
    .clk(clk), .rstN(rstN), .strb(strb), .busy(busy), .outReady(addrReady),
    .inLen(blkLen), .inRows(numRows), .inCols(numCols), .inPrime(prime),
    .inRoot(primRoot), .inOrder(rowOrder),
    .seqIdx(seqIdx), .primeIdx(primeIdx), .qRow(qRow), .rowIdx(rowIdx), .colIdx(colIdx),
    .cfgLen(cfgLen), .cfgRows(cfgRows), .cfgCols(cfgCols), .cfgPrime(cfgPrime),
    .primeHit(primeHit), .candPad(candPad),
    .outValid(addrValid), .outLast(outLast), .outAddr(addr)
  );

  assign done = addrValid && outLast;

  // R1
  reset_idle_chk: assert property (@(posedge clk)
    !rstN |=> (!addrValid && !done));

endmodule

// File: tb/tb_prime_ilv_addr_gen.sv
`timescale 1ns/1ps
module tb_prime_ilv_addr_gen;

  logic         clk = 1'b0;
  logic         rstN = 1'b0;
  logic         start = 1'b0;
  logic [12:0]  blkLen = '0;
  logic [4:0]   numRows = '0;
  logic [8:0]   numCols = '0;
  logic [8:0]   prime = '0;
  logic [4:0]   primRoot = '0;
  logic [99:0]  rowOrder = '0;
  logic         addrReady = 1'b0;
  logic         addrValid;
  logic [12:0]  addr;
  logic         done;

  always #5 clk = ~clk;

  prime_ilv_addr_gen dut (
    .clk(clk), .rstN(rstN), .start(start), .blkLen(blkLen), .numRows(numRows),
    .numCols(numCols), .prime(prime), .primRoot(primRoot), .rowOrder(rowOrder),
    .addrReady(addrReady), .addrValid(addrValid), .addr(addr), .done(done)
  );

  int nChecks = 0;
  int nErrors = 0;
  int cycles  = 0;

  int cK, cR, cC, cP, cV;
  int rowTab [20];
  int expSeq [5200];
  int expN;

  always @(posedge clk) cycles++;

  task automatic chk(bit ok, string tag, int act, int exp);
    nChecks++;
    if (!ok) begin
      nErrors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  function automatic bit tbPrime(int x);
    if (x < 2) return 0;
    for (int d = 2; d * d <= x; d++) if (x % d == 0) return 0;
    return 1;
  endfunction

  function automatic int primRootOf(int p);
    for (int g = 2; g < p; g++) begin
      int x = 1;
      bit ok = 1;
      for (int k = 1; k < p - 1; k++) begin
        x = (x * g) % p;
        if (x == 1) ok = 0;
      end
      if (ok) return g;
    end
    return 0;
  endfunction

  // configuration chosen from K; reverse=1 gives a descending row table
  task automatic pickCfg(int k, bit reverse);
    cK = k;
    cR = (k < 160) ? 5 : ((k <= 530) ? 10 : 20);
    cP = 7;
    while (!(tbPrime(cP) && cR * (cP + 1) >= k)) cP++;
    if (k <= cR * (cP - 1))  cC = cP - 1;
    else if (k <= cR * cP)   cC = cP;
    else                     cC = cP + 1;
    cV = primRootOf(cP);
    for (int i = 0; i < 20; i++) rowTab[i] = (i < cR) ? (reverse ? cR - 1 - i : i) : 0;
    if (!reverse) begin
      for (int i = cR - 1; i > 0; i--) begin
        int j = $urandom % (i + 1);
        int t = rowTab[i];
        rowTab[i] = rowTab[j];
        rowTab[j] = t;
      end
    end
  endtask

  // expected order from the requirement formulas
  task automatic buildRef();
    int s [256];
    int q [20];
    int cand;
    s[0] = 1;
    for (int j = 1; j < cP - 1; j++) s[j] = (cV * s[j-1]) % cP;
    q[0] = 1;
    cand = 6;
    for (int i = 1; i < cR; i++) begin
      do cand++; while (!(tbPrime(cand) && ((cP - 1) % cand) != 0));
      q[i] = cand;
    end
    expN = 0;
    for (int j = 0; j < cC; j++) begin
      for (int i = 0; i < cR; i++) begin
        int u;
        int a;
        if (j < cP - 1) u = s[(j * q[i]) % (cP - 1)] - ((cC == cP - 1) ? 1 : 0);
        else if (j == cP - 1) u = 0;
        else u = cP;
        a = rowTab[i] * cC + u;
        if (a < cK) begin
          expSeq[expN] = a;
          expN++;
        end
      end
    end
  endtask

  task automatic runBlock(int k, bit reverse, int readyPct, bit disturb, string tag);
    int idx;
    bit prevHold;
    int prevAddr;
    bit prevDone;
    int strayAt;
    pickCfg(k, reverse);
    buildRef();
    @(negedge clk);
    blkLen   = 13'(cK);
    numRows  = 5'(cR);
    numCols  = 9'(cC);
    prime    = 9'(cP);
    primRoot = 5'(cV);
    for (int i = 0; i < 20; i++) rowOrder[i*5 +: 5] = 5'(rowTab[i]);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    if (disturb) begin
      // R10: scramble the configuration pins while the block runs
      blkLen   = 13'($urandom);
      numRows  = 5'($urandom);
      numCols  = 9'($urandom);
      prime    = 9'($urandom);
      primRoot = 5'($urandom);
      rowOrder = {$urandom, $urandom, $urandom, $urandom};
    end
    idx = 0;
    prevHold = 0;
    prevAddr = 0;
    prevDone = 0;
    strayAt = disturb ? expN / 2 : -1;
    while (idx < expN) begin
      @(negedge clk);
      start = 1'b0;
      if (idx == strayAt) begin
        start = 1'b1;   // R9: stray start mid-block
        strayAt = -1;
      end
      if (prevHold) begin
        chk(addrValid == 1'b1 && int'(addr) == prevAddr && done == prevDone,
            "R8 hold", int'(addr), prevAddr);
      end
      addrReady = (($urandom % 100) < readyPct);
      if (addrValid && addrReady) begin
        chk(int'(addr) == expSeq[idx], tag, int'(addr), expSeq[idx]);
        chk(done == (idx == expN - 1), "R7 done", int'(done), int'(idx == expN - 1));
        idx++;
      end
      prevHold = addrValid && !addrReady;
      prevAddr = int'(addr);
      prevDone = done;
    end
    @(negedge clk);
    start = 1'b0;
    addrReady = 1'b1;
    for (int c = 0; c < 4; c++) begin
      @(negedge clk);
      chk(addrValid == 1'b0 && done == 1'b0, "R6 no extra address", int'(addrValid), 0);
    end
    chk(idx == expN && expN == cK, "R6 count", idx, cK);
    addrReady = 1'b0;
  endtask

  initial begin
    void'($urandom(32'h1d5e));
    repeat (4) @(negedge clk);
    chk(addrValid == 1'b0 && done == 1'b0, "R1 in reset", int'(addrValid), 0);
    rstN = 1'b1;
    addrReady = 1'b1;
    for (int c = 0; c < 5; c++) begin
      @(negedge clk);
      chk(addrValid == 1'b0 && done == 1'b0, "R1 idle after reset", int'(addrValid), 0);
    end
    addrReady = 1'b0;

    // directed corners
    runBlock(40,   1'b1, 100, 1'b0, "R2 R4 R5 min length");
    runBlock(145,  1'b0, 60,  1'b1, "R3 R4 R5 R11 C=p p=29");
    runBlock(150,  1'b0, 50,  1'b0, "R4 R5 R11 C=p+1");
    runBlock(160,  1'b1, 100, 1'b0, "R4 R5 R11 C=p-1 no padding");
    // random blocks
    for (int b = 0; b < 6; b++) begin
      int k = 40 + ($urandom % 1500);
      int rp = 30 + ($urandom % 71);
      runBlock(k, 1'b0, rp, b[0], "R2 R3 R4 R5 R11 random");
    end
    runBlock(5114, 1'b0, 90, 1'b1, "R4 R5 R11 max length");

    $display("Simulation finished: %0d checks, %0d errors", nChecks, nErrors);
    $finish;
  end

  initial begin
    wait (cycles >= 190000);
    nChecks++;
    nErrors++;
    $display("FAIL watchdog expired after %0d cycles", cycles);
    $display("Simulation finished: %0d checks, %0d errors", nChecks, nErrors);
    $finish;
  end

endmodule